// File: doc/BRIEF.md
# PCI Host Bridge Address Decoder

This block sits between a CPU bus and the configuration side of a simple PCI host bridge. It takes one CPU access at a time. Each access carries a space flag (memory or I/O), an address, a size code, a write flag and write data. The block sorts the access into one of four cases:

- a 4 MiB memory-mapped configuration window;
- a single interrupt-acknowledge byte;
- a configuration index/data port pair in I/O space;
- nothing.

Window and data-port accesses become configuration requests on a valid/ready channel. Read completions come back on a response strobe. Index-register and acknowledge accesses are answered locally. In the window, the block turns a one-hot device-select field of the address into a compact device number.

The block also folds the level-sensitive interrupt pins of the attached device slots onto the bridge's interrupt outputs, using a fixed two-way swizzle.

Back-pressure rules:
- CPU side: `cpu_req_ready` is high only when no access is in flight. A request may be held until it is taken. The response is a one-cycle `cpu_rsp_valid` strobe that cannot be stalled.
- Configuration side: `cfg_req_valid` stays high with a stable payload until `cfg_req_ready` is seen. `cfg_rsp_valid` is expected only after a read request. Outside that wait, it is ignored.

Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = reserved. The lane offset is address bits [1:0].

Top module: `pcihb_decode`

## Requirements
- R1: A memory access with address in [0x8080_0000, 0x80C0_0000) is forwarded as one configuration request. Request address bits [10:0] equal the access address bits [10:0], and bits [31:16] are zero.
- R2: Request address bits [15:11] hold the index i (0..10) of the lowest set bit among access address bits 11+i. If none of bits 11..21 is set, the field holds 11.
- R3: Window data is little-endian. Write data (the low bytes, sized by the size code) goes to byte lane offset onward. The enables are 0001, 0011 or 1111, shifted left by offset. Read data is taken from the same lanes with no reordering, right-aligned.
- R4: A 1-byte memory read at 0xBFFF_FFF0 returns {24'h0, iack_vector} as sampled at acceptance. It raises `iack_strobe` in the response cycle. A 1-byte write there has no effect and no error.
- R5: Any access of size code 1, 2 or 3 at 0xBFFF_FFF0 responds with error and read data all-ones. It does not raise `iack_strobe`.
- R6: The index register (I/O 0xCF8–0xCFB) accepts only 4-byte accesses at 0xCF8. A write stores the data with its byte order reversed, and a read returns it reversed back. Any other access there responds with error and leaves the register unchanged.
- R7: An access to I/O 0xCFC–0xCFF is forwarded with address {index[31:2], offset}. Data is big-endian: it is byte-reversed within its size, then placed in lanes as in R3. Read data goes through the inverse.
- R8: An access matching no region makes no configuration request. It responds without error, and read data is all-ones.
- R9: In the window or the data port, any of the following responds with error and all-ones read data and makes no request: size code 1 at an odd offset, size code 2 at a non-zero offset, or size code 3.
- R10: Timing of the handshake:
  - A locally answered access responds in the cycle after acceptance.
  - A forwarded write responds in the cycle after the config handshake.
  - A forwarded read responds in the cycle after `cfg_rsp_valid`.
  - `cpu_rsp_valid` lasts one cycle.
  - The config payload is stable while it waits for ready.
- R11: For k = 0, 1: `irq_out[k]` is the OR of `int_lvl[d*4+p]` over all device slots d and pins p with (p+d) mod 2 = k. The path is combinational. `irq_out[3:2]` stay low.
- R12: After reset the following hold:
  - `cpu_req_ready` is 1;
  - `cpu_rsp_valid`, `cfg_req_valid` and `iack_strobe` are 0;
  - the index register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access valid |
| cpu_req_ready | output | 1 | Block idle, access taken this cycle |
| cpu_req_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_req_addr | input | 32 | Access address |
| cpu_req_size | input | 2 | Size code |
| cpu_req_write | input | 1 | 1 = write |
| cpu_req_wdata | input | 32 | Right-aligned write data |
| cpu_rsp_valid | output | 1 | Response strobe |
| cpu_rsp_rdata | output | 32 | Right-aligned read data |
| cpu_rsp_err | output | 1 | Access rejected |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration request taken |
| cfg_req_addr | output | 32 | Configuration address |
| cfg_req_be | output | 4 | Byte-lane enables |
| cfg_req_write | output | 1 | Configuration write |
| cfg_req_wdata | output | 32 | Lane-placed write data |
| cfg_rsp_valid | input | 1 | Configuration read data valid |
| cfg_rsp_rdata | input | 32 | Lane-placed read data |
| iack_vector | input | 8 | Vector from the interrupt controller |
| iack_strobe | output | 1 | Acknowledge cycle taken |
| int_lvl | input | 16 | Device pin levels, bit d*4+p |
| irq_out | output | 4 | Bridge interrupt outputs |

## Verification
The hardest case is a forwarded read whose handshake is stalled and whose completion comes late. The lane offset, size and byte order must all survive that wait. The bench therefore answers every configuration request after a random number of stall cycles and a further random completion delay, over a mix of window and data-port accesses.

The "no select bit" device case almost never appears with uniform random offsets. So the generator first picks the lowest set select bit (or none) and only then randomizes the bits above it. Directed accesses add the acknowledge and index-register corners.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_WIN  = 3'd1,
    RG_IACK = 3'd2,
    RG_IDX  = 3'd3,
    RG_DATA = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } xact_st_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // reverse byte order inside the access width
  function automatic logic [31:0] swap_in_size(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return 4'b0011 << off;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic misaligned(input logic [1:0] off, input logic [1:0] sz);
    return (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0) || (sz == 2'd3);
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] d, input logic [1:0] off,
                                           input logic [1:0] sz, input logic sw);
    logic [31:0] t;
    t = d & size_mask(sz);
    if (sw) t = swap_in_size(t, sz);
    return t << {off, 3'b000};
  endfunction

  function automatic logic [31:0] lane_get(input logic [31:0] d, input logic [1:0] off,
                                           input logic [1:0] sz, input logic sw);
    logic [31:0] t;
    t = (d >> {off, 3'b000}) & size_mask(sz);
    if (sw) t = swap_in_size(t, sz);
    return t;
  endfunction

endpackage

// File: rtl/pcihb_addr_map.sv
module pcihb_addr_map
  import pcihb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE    = 32'h8080_0000,
  parameter int          WIN_LOG2    = 22,
  parameter int          SEL_LO      = 11,
  parameter int          SEL_N       = 11,
  parameter int          DEV_FIELD_W = 5,
  parameter logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0,
  parameter logic [31:0] IDX_PORT    = 32'h0000_0CF8,
  parameter logic [31:0] DATA_PORT   = 32'h0000_0CFC
) (
  input  logic        is_io,
  input  logic [31:0] addr,
  output region_e     region,
  output logic [31:0] win_cfg_addr
);

  localparam int FIELD_HI = SEL_LO + DEV_FIELD_W;

  logic [DEV_FIELD_W-1:0] dev_num;

  // lowest set select bit wins; none set gives SEL_N
  always_comb begin
    dev_num = DEV_FIELD_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (addr[SEL_LO + i]) dev_num = DEV_FIELD_W'(i);
    end
  end

  always_comb begin
    win_cfg_addr = '0;
    win_cfg_addr[SEL_LO-1:0] = addr[SEL_LO-1:0];
    win_cfg_addr[FIELD_HI-1:SEL_LO] = dev_num;
  end

  always_comb begin
    if (!is_io && addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2])
      region = RG_WIN;
    else if (!is_io && addr == IACK_ADDR)
      region = RG_IACK;
    else if (is_io && addr[31:2] == IDX_PORT[31:2])
      region = RG_IDX;
    else if (is_io && addr[31:2] == DATA_PORT[31:2])
      region = RG_DATA;
    else
      region = RG_NONE;
  end

endmodule

// File: rtl/pcihb_irq_swizzle.sv
module pcihb_irq_swizzle #(
  parameter int NUM_DEV    = 4,
  parameter int INT_PINS   = 4,
  parameter int NUM_IRQ    = 4,
  parameter int ROUTED_IRQ = 2
) (
  input  logic [NUM_DEV*INT_PINS-1:0] int_lvl,
  output logic [NUM_IRQ-1:0]          irq_out
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_out
    if (k < ROUTED_IRQ) begin : g_routed
      always_comb begin
        irq_out[k] = 1'b0;
        for (int d = 0; d < NUM_DEV; d++) begin
          for (int p = 0; p < INT_PINS; p++) begin
            if ((p + d) % ROUTED_IRQ == k) irq_out[k] = irq_out[k] | int_lvl[d*INT_PINS + p];
          end
        end
      end
    end else begin : g_unrouted
      assign irq_out[k] = 1'b0;
    end
  end

endmodule

// File: rtl/pcihb_xact.sv
module pcihb_xact
  import pcihb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_off,
  input  logic [31:0] req_wdata,
  input  region_e     region,
  input  logic [31:0] win_cfg_addr,
  input  logic [7:0]  iack_vector,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  output logic [31:0] cfg_addr,
  output logic [3:0]  cfg_be,
  output logic        cfg_write,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rvalid,
  input  logic [31:0] cfg_rdata,
  output logic        iack_strobe
);

  xact_st_e    st_q;
  logic [31:0] idx_q, caddr_q, cwd_q, rd_q;
  logic [3:0]  be_q;
  logic        cwr_q, swap_q, err_q, iack_q;
  logic [1:0]  off_q, size_q;

  logic        acc, n_fwd, n_err, n_idx_wr, n_iack, n_swap;
  logic [31:0] n_rd, n_caddr;

  always_comb begin
    acc      = req_valid && st_q == ST_IDLE;
    n_fwd    = 1'b0;
    n_err    = 1'b0;
    n_idx_wr = 1'b0;
    n_iack   = 1'b0;
    n_rd     = 32'hFFFF_FFFF;
    n_swap   = (region == RG_DATA);
    n_caddr  = (region == RG_DATA) ? {idx_q[31:2], req_off} : win_cfg_addr;
    case (region)
      RG_WIN, RG_DATA: begin
        if (misaligned(req_off, req_size)) n_err = 1'b1;
        else n_fwd = 1'b1;
      end
      RG_IACK: begin
        if (req_size != 2'd0) n_err = 1'b1;
        else if (!req_write) begin
          n_rd   = {24'h0, iack_vector};
          n_iack = 1'b1;
        end
      end
      RG_IDX: begin
        if (req_size != 2'd2 || req_off != 2'd0) n_err = 1'b1;
        else if (req_write) n_idx_wr = 1'b1;
        else n_rd = swap_in_size(idx_q, 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      caddr_q <= '0;
      cwd_q   <= '0;
      rd_q    <= '0;
      be_q    <= '0;
      cwr_q   <= 1'b0;
      swap_q  <= 1'b0;
      err_q   <= 1'b0;
      iack_q  <= 1'b0;
      off_q   <= '0;
      size_q  <= '0;
    end else begin
      iack_q <= acc && n_iack;
      case (st_q)
        ST_IDLE: if (acc) begin
          caddr_q <= n_caddr;
          be_q    <= lane_be(req_off, req_size);
          cwd_q   <= lane_put(req_wdata, req_off, req_size, n_swap);
          cwr_q   <= req_write;
          swap_q  <= n_swap;
          off_q   <= req_off;
          size_q  <= req_size;
          rd_q    <= n_rd;
          err_q   <= n_err;
          if (n_idx_wr) idx_q <= swap_in_size(req_wdata, 2'd2);
          st_q    <= n_fwd ? ST_CFG : ST_RESP;
        end
        ST_CFG: if (cfg_ready) st_q <= cwr_q ? ST_RESP : ST_WAIT;
        ST_WAIT: if (cfg_rvalid) begin
          rd_q <= lane_get(cfg_rdata, off_q, size_q, swap_q);
          st_q <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign cfg_valid   = (st_q == ST_CFG);
  assign rsp_valid   = (st_q == ST_RESP);
  assign cfg_addr    = caddr_q;
  assign cfg_be      = be_q;
  assign cfg_write   = cwr_q;
  assign cfg_wdata   = cwd_q;
  assign rsp_rdata   = rd_q;
  assign rsp_err     = err_q;
  assign iack_strobe = iack_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_be)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_IACK_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    iack_strobe |-> rsp_valid && !rsp_err); // R4
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_be != 4'b0000); // R3
  AST_ERR_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !$past(cfg_valid)); // R9

endmodule

// File: rtl/pcihb_decode.sv
module pcihb_decode
  import pcihb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
  parameter int          WIN_LOG2   = 22,
  parameter int          SEL_LO     = 11,
  parameter int          SEL_N      = 11,
  parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0,
  parameter logic [31:0] IDX_PORT   = 32'h0000_0CF8,
  parameter logic [31:0] DATA_PORT  = 32'h0000_0CFC,
  parameter int          NUM_DEV    = 4,
  parameter int          INT_PINS   = 4,
  parameter int          NUM_IRQ    = 4,
  parameter int          ROUTED_IRQ = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req_valid,
  output logic                        cpu_req_ready,
  input  logic                        cpu_req_io,
  input  logic [31:0]                 cpu_req_addr,
  input  logic [1:0]                  cpu_req_size,
  input  logic                        cpu_req_write,
  input  logic [31:0]                 cpu_req_wdata,
  output logic                        cpu_rsp_valid,
  output logic [31:0]                 cpu_rsp_rdata,
  output logic                        cpu_rsp_err,
  output logic                        cfg_req_valid,
  input  logic                        cfg_req_ready,
  output logic [31:0]                 cfg_req_addr,
  output logic [3:0]                  cfg_req_be,
  output logic                        cfg_req_write,
  output logic [31:0]                 cfg_req_wdata,
  input  logic                        cfg_rsp_valid,
  input  logic [31:0]                 cfg_rsp_rdata,
  input  logic [7:0]                  iack_vector,
  output logic                        iack_strobe,
  input  logic [NUM_DEV*INT_PINS-1:0] int_lvl,
  output logic [NUM_IRQ-1:0]          irq_out
);

  localparam int DEV_FIELD_W = $clog2(SEL_N + 1) + 1;

  region_e     region;
  logic [31:0] win_cfg_addr;

  pcihb_addr_map #(
    .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .SEL_LO(SEL_LO), .SEL_N(SEL_N),
    .DEV_FIELD_W(DEV_FIELD_W), .IACK_ADDR(IACK_ADDR), .IDX_PORT(IDX_PORT),
    .DATA_PORT(DATA_PORT)
  ) u_map (
    .is_io(cpu_req_io), .addr(cpu_req_addr), .region(region), .win_cfg_addr(win_cfg_addr)
  );

  pcihb_xact u_xact (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_write(cpu_req_write),
    .req_size(cpu_req_size), .req_off(cpu_req_addr[1:0]), .req_wdata(cpu_req_wdata),
    .region(region), .win_cfg_addr(win_cfg_addr), .iack_vector(iack_vector),
    .rsp_valid(cpu_rsp_valid), .rsp_rdata(cpu_rsp_rdata), .rsp_err(cpu_rsp_err),
    .cfg_valid(cfg_req_valid), .cfg_ready(cfg_req_ready), .cfg_addr(cfg_req_addr),
    .cfg_be(cfg_req_be), .cfg_write(cfg_req_write), .cfg_wdata(cfg_req_wdata),
    .cfg_rvalid(cfg_rsp_valid), .cfg_rdata(cfg_rsp_rdata), .iack_strobe(iack_strobe)
  );

  pcihb_irq_swizzle #(
    .NUM_DEV(NUM_DEV), .INT_PINS(INT_PINS), .NUM_IRQ(NUM_IRQ), .ROUTED_IRQ(ROUTED_IRQ)
  ) u_irq (
    .int_lvl(int_lvl), .irq_out(irq_out)
  );

endmodule

// File: tb/pcihb_decode_tb.sv
`timescale 1ns/1ps
module pcihb_decode_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_io = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic [1:0]  cpu_req_size = '0;
  logic        cpu_req_ready, cpu_rsp_valid, cpu_rsp_err;
  logic [31:0] cpu_rsp_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 1'b0, cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [3:0]  cfg_req_be;
  logic [7:0]  iack_vector = '0;
  logic        iack_strobe;
  logic [15:0] int_lvl = '0;
  logic [3:0]  irq_out;

  always #4 clk = ~clk;

  pcihb_decode u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_io(cpu_req_io),
    .cpu_req_addr(cpu_req_addr), .cpu_req_size(cpu_req_size), .cpu_req_write(cpu_req_write),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .cpu_rsp_err(cpu_rsp_err), .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_addr(cfg_req_addr), .cfg_req_be(cfg_req_be), .cfg_req_write(cfg_req_write),
    .cfg_req_wdata(cfg_req_wdata), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
    .iack_vector(iack_vector), .iack_strobe(iack_strobe), .int_lvl(int_lvl), .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_idx = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_mask(input logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_rev(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int b = 0; b < n; b++) r[8*(n-1-b) +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [3:0] m_be(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] r = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int b = 0; b < n; b++) r[(int'(off) + b) % 4] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_put(input logic [31:0] d, input logic [1:0] off,
                                        input logic [1:0] sz, input bit sw);
    logic [31:0] t = d & m_mask(sz);
    if (sw) t = m_rev(t, sz);
    return t << (8 * int'(off));
  endfunction

  function automatic logic [31:0] m_get(input logic [31:0] d, input logic [1:0] off,
                                        input logic [1:0] sz, input bit sw);
    logic [31:0] t = (d >> (8 * int'(off))) & m_mask(sz);
    if (sw) t = m_rev(t, sz);
    return t;
  endfunction

  function automatic logic [4:0] m_dev(input logic [31:0] a);
    logic [4:0] r = 5'd11;
    for (int i = 10; i >= 0; i--) if (a[11 + i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] cfg_mem(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_ABCD;
  endfunction

  task automatic access(input bit io, input logic [31:0] a, input logic [1:0] sz,
                        input bit wr, input logic [31:0] wd, input string tag);
    bit e_fwd = 0, e_err = 0, e_iack = 0, e_sw = 0, e_idx_wr = 0;
    logic [31:0] e_caddr = '0, e_rd = 32'hFFFF_FFFF, e_wd;
    logic [3:0] e_be;
    bit mis = (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0) || sz == 3;
    bit got = 0, seen = 0, hs = 0;
    int stall = $urandom_range(0, 3);
    int dly = -1;
    int lat = -1;
    logic [31:0] s_addr = '0, s_wd = '0, g_rd = '0;
    logic [3:0] s_be = '0;
    bit s_wr = 0, g_err = 0, g_iack = 0;

    if (!io && a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      if (mis) e_err = 1;
      else begin e_fwd = 1; e_caddr = {16'h0, m_dev(a), a[10:0]}; end
    end else if (!io && a == 32'hBFFF_FFF0) begin
      if (sz != 0) e_err = 1;
      else if (!wr) begin e_iack = 1; e_rd = {24'h0, iack_vector}; end
    end else if (io && a[31:2] == 30'h33E) begin
      if (sz != 2 || a[1:0] != 0) e_err = 1;
      else if (wr) e_idx_wr = 1;
      else e_rd = m_rev(m_idx, 2);
    end else if (io && a[31:2] == 30'h33F) begin
      e_sw = 1;
      if (mis) e_err = 1;
      else begin e_fwd = 1; e_caddr = {m_idx[31:2], a[1:0]}; end
    end
    e_be = m_be(a[1:0], sz);
    e_wd = m_put(wd, a[1:0], sz, e_sw);
    if (e_fwd && !wr) e_rd = m_get(cfg_mem(e_caddr), a[1:0], sz, e_sw);

    @(negedge clk);
    cpu_req_valid = 1; cpu_req_io = io; cpu_req_addr = a; cpu_req_size = sz;
    cpu_req_write = wr; cpu_req_wdata = wd;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      cpu_req_valid = 0;
      cfg_req_ready = 0;
      cfg_rsp_valid = 0;
      if (cpu_rsp_valid) begin
        got = 1; lat = c; g_rd = cpu_rsp_rdata; g_err = cpu_rsp_err; g_iack = iack_strobe;
        break;
      end
      if (cfg_req_valid && !hs) begin
        if (!seen) begin
          seen = 1; s_addr = cfg_req_addr; s_be = cfg_req_be; s_wd = cfg_req_wdata; s_wr = cfg_req_write;
        end
        if (stall == 0) begin
          cfg_req_ready = 1; hs = 1;
          if (!cfg_req_write) dly = $urandom_range(0, 3);
        end else stall--;
      end else if (hs && dly >= 0) begin
        if (dly == 0) begin cfg_rsp_valid = 1; cfg_rsp_rdata = cfg_mem(s_addr); dly = -1; end
        else dly--;
      end
    end

    chk(got, tag, "response seen", 32'(got), 32'd1);
    chk(g_err == e_err, tag, "error flag", 32'(g_err), 32'(e_err));
    chk(seen == e_fwd, tag, "config request made", 32'(seen), 32'(e_fwd));
    chk(g_iack == e_iack, tag, "iack strobe", 32'(g_iack), 32'(e_iack));
    if (!wr) chk(g_rd == e_rd, tag, "read data", g_rd, e_rd);
    if (!e_fwd) chk(lat == 0, "R10", "local response latency", 32'(lat), 32'd0);
    if (e_fwd && seen) begin
      chk(s_addr == e_caddr, tag, "config address", s_addr, e_caddr);
      chk(s_be == e_be, tag, "byte enables", 32'(s_be), 32'(e_be));
      chk(s_wr == wr, tag, "config write flag", 32'(s_wr), 32'(wr));
      if (wr) chk(s_wd == e_wd, tag, "config write data", s_wd, e_wd);
    end
    if (e_idx_wr) m_idx = m_rev(wd, 2);
  endtask

  task automatic irq_check(input logic [15:0] lv);
    logic [3:0] e = '0;
    int_lvl = lv;
    #1;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++)
        if (lv[d*4 + p]) e[(p + d) % 2] = 1'b1;
    chk(irq_out == e, "R11", "interrupt outputs", 32'(irq_out), 32'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(cpu_req_ready == 1, "R12", "ready after reset", 32'(cpu_req_ready), 32'd1);
    chk(cpu_rsp_valid == 0, "R12", "rsp valid after reset", 32'(cpu_rsp_valid), 32'd0);
    chk(cfg_req_valid == 0, "R12", "cfg valid after reset", 32'(cfg_req_valid), 32'd0);
    chk(iack_strobe == 0, "R12", "iack after reset", 32'(iack_strobe), 32'd0);
    access(1, 32'hCF8, 2, 0, 0, "R12");

    // R1 R2 device field
    access(0, 32'h8080_0814, 2, 0, 0, "R2");
    access(0, 32'h8080_0000, 2, 0, 0, "R2");
    access(0, 32'h80A0_0000, 2, 1, 32'hCAFE_F00D, "R2");
    access(0, 32'h8088_8000 | 32'h7FC, 2, 0, 0, "R2");
    access(0, 32'h80BF_FFFC, 2, 0, 0, "R1");
    // R3 lanes
    access(0, 32'h8081_0003, 0, 1, 32'hFFFF_FF5A, "R3");
    access(0, 32'h8081_0002, 1, 0, 0, "R3");
    access(0, 32'h8081_0001, 0, 0, 0, "R3");
    // R4 R5 acknowledge
    iack_vector = 8'h9C;
    access(0, 32'hBFFF_FFF0, 0, 0, 0, "R4");
    access(0, 32'hBFFF_FFF0, 0, 1, 32'h11, "R4");
    access(0, 32'hBFFF_FFF0, 1, 0, 0, "R5");
    access(0, 32'hBFFF_FFF0, 3, 0, 0, "R5");
    // R6 index register
    access(1, 32'hCF8, 2, 1, 32'h1122_3344, "R6");
    access(1, 32'hCF8, 2, 0, 0, "R6");
    access(1, 32'hCF8, 0, 1, 32'hEE, "R6");
    access(1, 32'hCF9, 1, 0, 0, "R6");
    access(1, 32'hCF8, 2, 0, 0, "R6");
    // R7 data port
    access(1, 32'hCFC, 2, 1, 32'hAABB_CCDD, "R7");
    access(1, 32'hCFE, 1, 0, 0, "R7");
    access(1, 32'hCFD, 0, 1, 32'h77, "R7");
    // R8 unmapped
    access(0, 32'h1000_0000, 2, 0, 0, "R8");
    access(0, 32'h80C0_0000, 2, 0, 0, "R8");
    access(0, 32'h807F_FFFC, 2, 0, 0, "R8");
    access(1, 32'hCF0, 2, 1, 32'h1, "R8");
    access(0, 32'h0000_0CFC, 2, 0, 0, "R8");
    // R9 misaligned
    access(0, 32'h8080_1001, 1, 0, 0, "R9");
    access(0, 32'h8080_1002, 2, 1, 32'h5, "R9");
    access(0, 32'h8080_1000, 3, 0, 0, "R9");
    access(1, 32'hCFD, 2, 0, 0, "R9");

    // R11 directed and random
    irq_check(16'h0000);
    irq_check(16'h0001);
    irq_check(16'h0010);
    irq_check(16'h0020);
    irq_check(16'h8000);
    for (int n = 0; n < 40; n++) irq_check(16'($urandom));
    irq_check(16'h0000);

    // random mix, R10 stalls via the responder
    for (int n = 0; n < 500; n++) begin
      int k = $urandom_range(0, 9);
      logic [1:0] sz = ($urandom_range(0, 7) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      bit wr = 1'($urandom_range(0, 1));
      logic [31:0] wd = $urandom;
      logic [31:0] a;
      iack_vector = 8'($urandom);
      if (k <= 4) begin
        int sel = $urandom_range(0, 11);
        logic [10:0] hi = 11'($urandom);
        if (sel == 11) hi = '0;
        else begin
          hi = hi & ~((11'd1 << sel) - 11'd1);
          hi[sel] = 1'b1;
        end
        a = {10'h202, hi, 11'($urandom)};
        access(0, a, sz, wr, wd, "R1");
      end else if (k == 5) begin
        access(0, 32'hBFFF_FFF0, sz, wr, wd, "R4");
      end else if (k == 6) begin
        a = 32'hCF8 + (($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 3)) : 32'd0);
        access(1, a, sz, wr, wd, "R6");
      end else if (k <= 8) begin
        access(1, 32'hCFC + 32'($urandom_range(0, 3)), sz, wr, wd, "R7");
      end else begin
        access(1'($urandom_range(0, 1)), $urandom, sz, wr, wd, "R8");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule